// File: doc/BRIEF.md
# Paravirtual Device Control Register File

This block is the register window that a legacy paravirtual I/O function exposes through its I/O BAR. A host-side bus agent issues byte, word or dword accesses at an offset inside the window. The block holds the common control state: the offered and accepted feature masks, a queue selector, a page frame number and an interrupt vector for each queue, an 8-bit device status and an 8-bit interrupt status that clears when it is read. It also raises the notify strobe toward the ring engine, produces a one-cycle device reset pulse, and drives either a level interrupt line or a message request that carries a vector number.

Offsets past the common registers go to a pass-through port, rebased to zero, for the device-specific configuration space. Where that space begins depends on the `msg_en` input. With message interrupts enabled, two vector registers sit at offsets 20 and 22 and the device space starts at 24. With them disabled, the device space starts at 20. The window covers the common registers plus the device configuration length, rounded up to a power of two, and that size sets the address width.

Top module: `pvctl_regfile`

## Requirements
- R1: After `rst`, guest features, every page frame, queue select, status and ISR read 0, both vector registers read 16'hFFFF, and `intx`, `dev_reset`, `notify_valid`, `msg_valid` and `vec_used` are 0.
- R2: Offset 0 reads the device feature parameter ORed with bit 24 (notify on empty) and bit 30 (bad feature). Writes to offset 0 are dropped.
- R3: A write to offset 4 stores the data as guest features. When data bit 30 is set, the block stores host features AND the fallback mask instead, or 0 when `HAS_FALLBACK` is 0.
- R4: Offset 8 writes and reads the page frame of the selected queue. Offset 12 reads `QSIZE` and ignores writes. A write of value q below `NQ` to offset 16 pulses `notify_valid` with `notify_queue`=q and `notify_base` = the page frame of queue q shifted left by 12. A write of any other value gives no pulse.
- R5: A write to offset 14 sets the queue selector only when the value is below `NQ`. Otherwise the selector keeps its value.
- R6: Writing 0 to offset 8, or writing a value whose low byte is 0 to offset 18, pulses `dev_reset` in the next cycle. It also clears status, ISR, guest features, queue select and all page frames, sets every vector to 16'hFFFF, and so leaves `vec_used` at 0.
- R7: A read of offset 19 returns the ISR and clears it. An event in the same cycle is ORed in after the clear. A queue event sets ISR bit 0, and a config event sets bits 0 and 1.
- R8: With `msg_en`=0, `intx` equals ISR bit 0. With `msg_en`=1, `intx` is 0.
- R9: With `msg_en`=1, an event pulses `msg_valid` in the next cycle with `msg_vec` = the config vector (config event) or the event queue's vector (queue event). No pulse occurs when that vector is 16'hFFFF.
- R10: A write to offset 20 (config vector) or 22 (selected queue's vector) stores the value when it is below `NVEC`, else 16'hFFFF. `vec_used[v]` is 1 exactly when some vector register holds v.
- R11: With `msg_en`=1, offsets 24 up to 24+`DEV_CFG_LEN`-1 go to the pass-through port. With `msg_en`=0, the range starts at 20. `dev_cfg_addr` is the offset minus the start, `dev_cfg_valid` follows the access in the same cycle, and reads return `dev_cfg_rdata`.
- R12: Reads of unmapped common offsets (such as 1, 13 and 16) and of offsets past the device range return 32'hFFFFFFFF. Writes there, and writes to read-only offsets 0, 12 and 19, change nothing.
- R13: Write data is zero-extended from the access size (`acc_size` 0 byte, 1 word, 2 or 3 dword). A read raises `rd_valid` one cycle after the access, with the register value zero-extended whatever the size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_en | input | 1 | Message interrupts enabled |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 write, 0 read |
| acc_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| acc_addr | input | ADDR_W | Offset inside the window |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| dev_cfg_valid | output | 1 | Device-space access strobe |
| dev_cfg_write | output | 1 | Device-space write |
| dev_cfg_size | output | 2 | Device-space access size |
| dev_cfg_addr | output | ADDR_W | Rebased device-space offset |
| dev_cfg_wdata | output | 32 | Device-space write data |
| dev_cfg_rdata | input | 32 | Device-space read data |
| evt_valid | input | 1 | Interrupt event from the device |
| evt_cfg | input | 1 | 1 config event, 0 queue event |
| evt_queue | input | QSEL_W | Queue of a queue event |
| intx | output | 1 | Level interrupt line |
| msg_valid | output | 1 | Message interrupt request |
| msg_vec | output | 16 | Requested vector |
| notify_valid | output | 1 | Queue notify strobe |
| notify_queue | output | QSEL_W | Notified queue |
| notify_base | output | 32+PFN_SHIFT | Base address of the notified queue |
| dev_reset | output | 1 | Device reset pulse |
| vec_used | output | NVEC | Vectors currently allocated |

## Verification
Every registered result is due one clock edge after the access or event that causes it. This covers read data, ISR set and clear, notify, message request and the reset pulse. `intx` and `vec_used` follow their state registers, so they change at that same edge. The pass-through strobe and the rebased address are combinational and valid in the cycle of the access. The bench drives each stimulus on a falling edge and checks the pass-through outputs shortly after. It advances its behavioural model once, then compares every registered output at the next falling edge, so each result is taken exactly one edge after its cause.

// File: rtl/pvctl_pkg.sv
package pvctl_pkg;

    // common register offsets; the host driver decodes these
    localparam int OFS_HOSTF  = 0;
    localparam int OFS_GUESTF = 4;
    localparam int OFS_PFN    = 8;
    localparam int OFS_QNUM   = 12;
    localparam int OFS_QSEL   = 14;
    localparam int OFS_NOTIFY = 16;
    localparam int OFS_STATUS = 18;
    localparam int OFS_ISR    = 19;
    localparam int OFS_CFGVEC = 20;
    localparam int OFS_QVEC   = 22;

    // start of device space with and without message interrupts
    localparam int COMMON_PLAIN = 20;
    localparam int COMMON_MSG   = 24;

    localparam int FEAT_EMPTY_BIT = 24;
    localparam int FEAT_BAD_BIT   = 30;

    localparam logic [15:0] NO_VECTOR  = 16'hFFFF;
    localparam logic [7:0]  ISR_QUEUE  = 8'h01;
    localparam logic [7:0]  ISR_CONFIG = 8'h03;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_WIDE  = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_HOSTF,
        SEL_GUESTF,
        SEL_PFN,
        SEL_QNUM,
        SEL_QSEL,
        SEL_NOTIFY,
        SEL_STATUS,
        SEL_ISR,
        SEL_CFGVEC,
        SEL_QVEC,
        SEL_DEVCFG
    } reg_sel_e;

    typedef struct packed {
        logic        is_cfg;
        logic [15:0] vec;
    } irq_src_t;

    function automatic logic [31:0] fit_size(acc_size_e sz, logic [31:0] d);
        case (sz)
            SZ_BYTE: return {24'h0, d[7:0]};
            SZ_WORD: return {16'h0, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [15:0] vec_or_none(logic [31:0] req, int nvec);
        if (req < 32'(nvec)) return req[15:0];
        return NO_VECTOR;
    endfunction

    function automatic int pow2_ceil(int n);
        int p;
        p = 1;
        while (p < n) p = p * 2;
        return p;
    endfunction

endpackage

// File: rtl/pvctl_decode.sv
module pvctl_decode
    import pvctl_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DEV_CFG_LEN = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              msg_en,
    output reg_sel_e          sel,
    output logic [ADDR_W-1:0] dev_off
);

    int a;
    int base;

    always_comb begin
        a       = int'(addr);
        base    = msg_en ? COMMON_MSG : COMMON_PLAIN;
        dev_off = ADDR_W'(a - base);
        sel     = SEL_NONE;
        if (a >= base) begin
            if (a < base + DEV_CFG_LEN) sel = SEL_DEVCFG;
        end else begin
            case (a)
                OFS_HOSTF:  sel = SEL_HOSTF;
                OFS_GUESTF: sel = SEL_GUESTF;
                OFS_PFN:    sel = SEL_PFN;
                OFS_QNUM:   sel = SEL_QNUM;
                OFS_QSEL:   sel = SEL_QSEL;
                OFS_NOTIFY: sel = SEL_NOTIFY;
                OFS_STATUS: sel = SEL_STATUS;
                OFS_ISR:    sel = SEL_ISR;
                OFS_CFGVEC: sel = SEL_CFGVEC;
                OFS_QVEC:   sel = SEL_QVEC;
                default:    sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pvctl_queue_bank.sv
module pvctl_queue_bank
    import pvctl_pkg::*;
#(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic [QW-1:0]         sel,
    input  logic                  wr_pfn,
    input  logic [31:0]           pfn_wdata,
    input  logic                  wr_vec,
    input  logic [15:0]           vec_wdata,
    input  logic [QW-1:0]         ntf_q,
    input  logic [QW-1:0]         evt_q,
    output logic [31:0]           pfn_sel,
    output logic [31:0]           pfn_ntf,
    output logic [15:0]           vec_sel,
    output logic [15:0]           vec_evt,
    output logic [NQ-1:0][15:0]   vec_all
);

    logic [NQ-1:0][31:0] pfn_r;
    logic [NQ-1:0][15:0] vec_r;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pfn_r <= '0;
            vec_r <= {NQ{NO_VECTOR}};
        end else begin
            if (wr_pfn) pfn_r[sel] <= pfn_wdata;
            if (wr_vec) vec_r[sel] <= vec_wdata;
        end
    end

    assign pfn_sel = pfn_r[sel];
    assign pfn_ntf = pfn_r[ntf_q];
    assign vec_sel = vec_r[sel];
    assign vec_evt = vec_r[evt_q];
    assign vec_all = vec_r;

endmodule

// File: rtl/pvctl_irq.sv
module pvctl_irq
    import pvctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        msg_en,
    input  logic        isr_rd,
    input  logic        evt_valid,
    input  irq_src_t    src,
    output logic [7:0]  isr,
    output logic        intx,
    output logic        msg_valid,
    output logic [15:0] msg_vec
);

    logic [7:0] isr_next;

    always_comb begin
        isr_next = isr_rd ? 8'h00 : isr;
        if (evt_valid) isr_next = isr_next | (src.is_cfg ? ISR_CONFIG : ISR_QUEUE);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            isr <= 8'h00;
        end else begin
            isr <= isr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_vec   <= NO_VECTOR;
        end else begin
            msg_valid <= evt_valid && msg_en && !clear && (src.vec != NO_VECTOR);
            msg_vec   <= src.vec;
        end
    end

    assign intx = isr[0] & ~msg_en;

endmodule

// File: rtl/pvctl_regfile.sv
module pvctl_regfile
    import pvctl_pkg::*;
#(
    parameter int          NQ           = 4,
    parameter int          QSIZE        = 256,
    parameter int          NVEC         = 3,
    parameter int          DEV_CFG_LEN  = 12,
    parameter logic [31:0] DEV_FEATURES = 32'h0000_0021,
    parameter logic [31:0] FALLBACK_MASK = 32'h0000_0001,
    parameter bit          HAS_FALLBACK = 1'b1,
    parameter int          PFN_SHIFT    = 12,
    localparam int         QSEL_W       = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int         BAR_BYTES    = pow2_ceil(COMMON_MSG + DEV_CFG_LEN),
    localparam int         ADDR_W       = $clog2(BAR_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    msg_en,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic [1:0]              acc_size,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [31:0]             acc_wdata,
    output logic                    rd_valid,
    output logic [31:0]             rd_data,
    output logic                    dev_cfg_valid,
    output logic                    dev_cfg_write,
    output logic [1:0]              dev_cfg_size,
    output logic [ADDR_W-1:0]       dev_cfg_addr,
    output logic [31:0]             dev_cfg_wdata,
    input  logic [31:0]             dev_cfg_rdata,
    input  logic                    evt_valid,
    input  logic                    evt_cfg,
    input  logic [QSEL_W-1:0]       evt_queue,
    output logic                    intx,
    output logic                    msg_valid,
    output logic [15:0]             msg_vec,
    output logic                    notify_valid,
    output logic [QSEL_W-1:0]       notify_queue,
    output logic [31+PFN_SHIFT:0]   notify_base,
    output logic                    dev_reset,
    output logic [NVEC-1:0]         vec_used
);

    localparam logic [31:0] HOST_FEAT = DEV_FEATURES
                                      | (32'h1 << FEAT_EMPTY_BIT)
                                      | (32'h1 << FEAT_BAD_BIT);
    localparam logic [31:0] BAD_FALLBACK = HAS_FALLBACK ? (HOST_FEAT & FALLBACK_MASK) : 32'h0;

    reg_sel_e          sel;
    logic [ADDR_W-1:0] dev_off;
    logic              acc_rd;
    logic              acc_wr;
    logic [31:0]       wd;

    logic [31:0]       guest_q;
    logic [7:0]        status_q;
    logic [QSEL_W-1:0] qsel_q;
    logic [15:0]       cfgvec_q;

    logic [31:0]       pfn_sel;
    logic [31:0]       pfn_ntf;
    logic [15:0]       vec_sel;
    logic [15:0]       vec_evt;
    logic [NQ-1:0][15:0] vec_all;
    logic [7:0]        isr_q;

    logic wr_guest, wr_pfn, wr_qsel, wr_notify, wr_status, wr_cfgvec, wr_qvec;
    logic clear;
    logic ntf_hit;
    irq_src_t src;
    logic [31:0] rd_next;

    pvctl_decode #(
        .ADDR_W      (ADDR_W),
        .DEV_CFG_LEN (DEV_CFG_LEN)
    ) u_decode (
        .addr    (acc_addr),
        .msg_en  (msg_en),
        .sel     (sel),
        .dev_off (dev_off)
    );

    assign acc_rd = acc_valid & ~acc_write;
    assign acc_wr = acc_valid &  acc_write;
    assign wd     = fit_size(acc_size_e'(acc_size), acc_wdata);

    assign wr_guest  = acc_wr && (sel == SEL_GUESTF);
    assign wr_pfn    = acc_wr && (sel == SEL_PFN);
    assign wr_qsel   = acc_wr && (sel == SEL_QSEL);
    assign wr_notify = acc_wr && (sel == SEL_NOTIFY);
    assign wr_status = acc_wr && (sel == SEL_STATUS);
    assign wr_cfgvec = acc_wr && (sel == SEL_CFGVEC);
    assign wr_qvec   = acc_wr && (sel == SEL_QVEC);

    // a zero page frame or a zero status byte restarts the device
    assign clear   = (wr_pfn && (wd == 32'h0)) || (wr_status && (wd[7:0] == 8'h00));
    assign ntf_hit = wr_notify && (wd < 32'(NQ));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            guest_q  <= 32'h0;
            status_q <= 8'h00;
            qsel_q   <= '0;
            cfgvec_q <= NO_VECTOR;
        end else begin
            if (wr_guest)  guest_q  <= wd[FEAT_BAD_BIT] ? BAD_FALLBACK : wd;
            if (wr_status) status_q <= wd[7:0];
            if (wr_qsel && (wd < 32'(NQ))) qsel_q <= wd[QSEL_W-1:0];
            if (wr_cfgvec) cfgvec_q <= vec_or_none(wd, NVEC);
        end
    end

    pvctl_queue_bank #(
        .NQ (NQ),
        .QW (QSEL_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .sel       (qsel_q),
        .wr_pfn    (wr_pfn && (wd != 32'h0)),
        .pfn_wdata (wd),
        .wr_vec    (wr_qvec),
        .vec_wdata (vec_or_none(wd, NVEC)),
        .ntf_q     (wd[QSEL_W-1:0]),
        .evt_q     (evt_queue),
        .pfn_sel   (pfn_sel),
        .pfn_ntf   (pfn_ntf),
        .vec_sel   (vec_sel),
        .vec_evt   (vec_evt),
        .vec_all   (vec_all)
    );

    assign src.is_cfg = evt_cfg;
    assign src.vec    = evt_cfg ? cfgvec_q : vec_evt;

    pvctl_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .msg_en    (msg_en),
        .isr_rd    (acc_rd && (sel == SEL_ISR)),
        .evt_valid (evt_valid),
        .src       (src),
        .isr       (isr_q),
        .intx      (intx),
        .msg_valid (msg_valid),
        .msg_vec   (msg_vec)
    );

    always_comb begin
        case (sel)
            SEL_HOSTF:  rd_next = HOST_FEAT;
            SEL_GUESTF: rd_next = guest_q;
            SEL_PFN:    rd_next = pfn_sel;
            SEL_QNUM:   rd_next = {16'h0, 16'(QSIZE)};
            SEL_QSEL:   rd_next = 32'(qsel_q);
            SEL_STATUS: rd_next = {24'h0, status_q};
            SEL_ISR:    rd_next = {24'h0, isr_q};
            SEL_CFGVEC: rd_next = {16'h0, cfgvec_q};
            SEL_QVEC:   rd_next = {16'h0, vec_sel};
            SEL_DEVCFG: rd_next = dev_cfg_rdata;
            default:    rd_next = 32'hFFFF_FFFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid     <= 1'b0;
            rd_data      <= 32'h0;
            notify_valid <= 1'b0;
            notify_queue <= '0;
            notify_base  <= '0;
            dev_reset    <= 1'b0;
        end else begin
            rd_valid     <= acc_rd;
            if (acc_rd) rd_data <= rd_next;
            notify_valid <= ntf_hit;
            if (ntf_hit) begin
                notify_queue <= wd[QSEL_W-1:0];
                notify_base  <= {pfn_ntf, {PFN_SHIFT{1'b0}}};
            end
            dev_reset    <= clear;
        end
    end

    assign dev_cfg_valid = acc_valid && (sel == SEL_DEVCFG);
    assign dev_cfg_write = acc_write;
    assign dev_cfg_size  = acc_size;
    assign dev_cfg_addr  = dev_off;
    assign dev_cfg_wdata = acc_wdata;

    for (genvar v = 0; v < NVEC; v++) begin : g_used
        logic hit;
        always_comb begin
            hit = (cfgvec_q == 16'(v));
            for (int q = 0; q < NQ; q++) begin
                if (vec_all[q] == 16'(v)) hit = 1'b1;
            end
        end
        assign vec_used[v] = hit;
    end

endmodule

// File: rtl/pvctl_regfile_chk.sv
module pvctl_regfile_chk #(
    parameter int NVEC   = 3,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              msg_en,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              rd_valid,
    input logic              intx,
    input logic              dev_reset,
    input logic [NVEC-1:0]   vec_used,
    input logic              msg_valid,
    input logic [15:0]       msg_vec,
    input logic              evt_valid,
    input logic              dev_cfg_valid
);

    assert_intx_muted_R8: assert property (@(posedge clk) disable iff (rst)
        msg_en |-> !intx);

    assert_isr_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr == ADDR_W'(19) && !evt_valid) |=> !intx);

    assert_reset_releases_R6: assert property (@(posedge clk) disable iff (rst)
        dev_reset |-> (vec_used == '0));

    assert_msg_vector_valid_R9: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_vec < 16'(NVEC)));

    assert_msg_cause_R9: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past(evt_valid && msg_en));

    assert_read_response_R13: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> rd_valid);

    assert_devcfg_gated_R11: assert property (@(posedge clk) disable iff (rst)
        dev_cfg_valid |-> acc_valid);

endmodule

bind pvctl_regfile pvctl_regfile_chk #(
    .NVEC   (NVEC),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .msg_en        (msg_en),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .rd_valid      (rd_valid),
    .intx          (intx),
    .dev_reset     (dev_reset),
    .vec_used      (vec_used),
    .msg_valid     (msg_valid),
    .msg_vec       (msg_vec),
    .evt_valid     (evt_valid),
    .dev_cfg_valid (dev_cfg_valid)
);

// File: tb/test_pvctl_regfile.sv
module test_pvctl_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NQ   = 4;
    localparam int NVEC = 3;
    localparam int DCL  = 12;
    localparam int AW   = 6;
    localparam logic [31:0] HOSTF = 32'h4100_0021;
    localparam logic [31:0] ONES  = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic msg_en = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0] acc_size = 2'd2;
    logic [AW-1:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic dev_cfg_valid, dev_cfg_write;
    logic [1:0] dev_cfg_size;
    logic [AW-1:0] dev_cfg_addr;
    logic [31:0] dev_cfg_wdata, dev_cfg_rdata;
    logic evt_valid = 1'b0, evt_cfg = 1'b0;
    logic [1:0] evt_queue = '0;
    logic intx, msg_valid, notify_valid, dev_reset;
    logic [15:0] msg_vec;
    logic [1:0] notify_queue;
    logic [43:0] notify_base;
    logic [NVEC-1:0] vec_used;

    pvctl_regfile i_pvctl_regfile (
        .clk(clk), .rst(rst), .msg_en(msg_en),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dev_cfg_valid(dev_cfg_valid), .dev_cfg_write(dev_cfg_write),
        .dev_cfg_size(dev_cfg_size), .dev_cfg_addr(dev_cfg_addr),
        .dev_cfg_wdata(dev_cfg_wdata), .dev_cfg_rdata(dev_cfg_rdata),
        .evt_valid(evt_valid), .evt_cfg(evt_cfg), .evt_queue(evt_queue),
        .intx(intx), .msg_valid(msg_valid), .msg_vec(msg_vec),
        .notify_valid(notify_valid), .notify_queue(notify_queue),
        .notify_base(notify_base), .dev_reset(dev_reset), .vec_used(vec_used)
    );

    assign dev_cfg_rdata = 32'hC0DE_0000 | 32'(dev_cfg_addr);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // behavioural model state
    logic [31:0] m_guest;
    logic [31:0] m_pfn [NQ];
    logic [15:0] m_qvec [NQ];
    logic [15:0] m_cfgvec;
    int          m_sel;
    logic [7:0]  m_status, m_isr;

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void m_reset();
        m_guest = 0; m_sel = 0; m_status = 0; m_isr = 0; m_cfgvec = 16'hFFFF;
        for (int q = 0; q < NQ; q++) begin
            m_pfn[q] = 0;
            m_qvec[q] = 16'hFFFF;
        end
    endfunction

    function automatic logic [31:0] fit(logic [1:0] sz, logic [31:0] d);
        if (sz == 2'd0) return d & 32'hFF;
        if (sz == 2'd1) return d & 32'hFFFF;
        return d;
    endfunction

    function automatic int dev_start();
        return msg_en ? 24 : 20;
    endfunction

    function automatic logic [31:0] m_read(int a);
        int b = dev_start();
        if (a >= b) return (a < b + DCL) ? (32'hC0DE_0000 | 32'(a - b)) : ONES;
        case (a)
            0:  return HOSTF;
            4:  return m_guest;
            8:  return m_pfn[m_sel];
            12: return 32'd256;
            14: return 32'(m_sel);
            18: return {24'h0, m_status};
            19: return {24'h0, m_isr};
            20: return {16'h0, m_cfgvec};
            22: return {16'h0, m_qvec[m_sel]};
            default: return ONES;
        endcase
    endfunction

    function automatic logic [15:0] vsel(logic [31:0] d);
        return (d < NVEC) ? d[15:0] : 16'hFFFF;
    endfunction

    task automatic step(bit v, bit w, logic [1:0] sz, int a, logic [31:0] d,
                        bit ev, bit ecfg, int eq);
        bit e_rd, e_ntf, e_msg, do_rst, in_dev;
        logic [31:0] e_data, dd;
        logic [15:0] e_vec, vv;
        logic [43:0] e_base;
        logic [7:0]  isr_n;
        int e_q;
        logic [NVEC-1:0] e_used;
        acc_valid = v; acc_write = w; acc_size = sz; acc_addr = AW'(a); acc_wdata = d;
        evt_valid = ev; evt_cfg = ecfg; evt_queue = 2'(eq);
        #1;
        in_dev = v && (a >= dev_start()) && (a < dev_start() + DCL);
        chk("dev_cfg_valid", 64'(dev_cfg_valid), 64'(in_dev));
        if (in_dev) chk("dev_cfg_addr", 64'(dev_cfg_addr), 64'(a - dev_start()));
        e_rd = v && !w; e_data = 0; e_ntf = 0; e_msg = 0; do_rst = 0;
        e_vec = 0; e_q = 0; e_base = 0;
        if (e_rd) e_data = m_read(a);
        isr_n = m_isr;
        if (e_rd && a == 19) isr_n = 0;
        if (ev) begin
            vv = ecfg ? m_cfgvec : m_qvec[eq];
            e_msg = msg_en && (vv != 16'hFFFF);
            e_vec = vv;
            isr_n = isr_n | (ecfg ? 8'h03 : 8'h01);
        end
        if (v && w && a < dev_start()) begin
            dd = fit(sz, d);
            case (a)
                4:  m_guest = dd[30] ? (HOSTF & 32'h1) : dd;
                8:  if (dd == 0) do_rst = 1; else m_pfn[m_sel] = dd;
                14: if (dd < NQ) m_sel = int'(dd);
                16: if (dd < NQ) begin
                        e_ntf = 1; e_q = int'(dd); e_base = {m_pfn[dd], 12'h0};
                    end
                18: begin m_status = dd[7:0]; if (dd[7:0] == 0) do_rst = 1; end
                20: m_cfgvec = vsel(dd);
                22: m_qvec[m_sel] = vsel(dd);
                default: ;
            endcase
        end
        m_isr = isr_n;
        if (do_rst) begin
            m_reset();
            e_msg = 0;
        end
        for (int u = 0; u < NVEC; u++) begin
            e_used[u] = (m_cfgvec == 16'(u));
            for (int q = 0; q < NQ; q++) if (m_qvec[q] == 16'(u)) e_used[u] = 1'b1;
        end
        @(negedge clk);
        chk("rd_valid", 64'(rd_valid), 64'(e_rd));
        if (e_rd) chk("rd_data", 64'(rd_data), 64'(e_data));
        chk("intx", 64'(intx), 64'(!msg_en && m_isr[0]));
        chk("dev_reset", 64'(dev_reset), 64'(do_rst));
        chk("notify_valid", 64'(notify_valid), 64'(e_ntf));
        if (e_ntf) begin
            chk("notify_queue", 64'(notify_queue), 64'(e_q));
            chk("notify_base", 64'(notify_base), 64'(e_base));
        end
        chk("msg_valid", 64'(msg_valid), 64'(e_msg));
        if (e_msg) chk("msg_vec", 64'(msg_vec), 64'(e_vec));
        chk("vec_used", 64'(vec_used), 64'(e_used));
    endtask

    task automatic rd(int a, logic [1:0] sz = 2'd2);
        step(1, 0, sz, a, 32'h0, 0, 0, 0);
    endtask
    task automatic wr(int a, logic [31:0] d, logic [1:0] sz = 2'd2);
        step(1, 1, sz, a, d, 0, 0, 0);
    endtask
    task automatic evt(bit cfg, int q);
        step(0, 0, 2'd2, 0, 32'h0, 1, cfg, q);
    endtask
    task automatic idle();
        step(0, 0, 2'd2, 0, 32'h0, 0, 0, 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        chk("rd_valid", 64'(rd_valid), 64'h0);
        chk("intx", 64'(intx), 64'h0);
        chk("dev_reset", 64'(dev_reset), 64'h0);
        chk("notify_valid", 64'(notify_valid), 64'h0);
        chk("msg_valid", 64'(msg_valid), 64'h0);
        chk("vec_used", 64'(vec_used), 64'h0);
        rd(4); rd(8); rd(14); rd(18); rd(19);
        msg_en = 1'b1;
        rd(20); rd(22);
        msg_en = 1'b0;

        tag = "R2";
        rd(0);
        wr(0, 32'h0);
        rd(0);
        rd(0, 2'd0);

        tag = "R3";
        wr(4, 32'h0000_0005); rd(4);
        wr(4, 32'h4000_0007); rd(4);

        tag = "R13";
        wr(4, 32'h1234_5678, 2'd0); rd(4);
        wr(4, 32'h1234_5678, 2'd1); rd(4, 2'd0);
        wr(4, 32'h1234_5678, 2'd3); rd(4, 2'd1);

        tag = "R5";
        wr(14, 2); rd(14);
        wr(14, 4); rd(14);
        wr(14, 32'h0001_0001); rd(14);
        wr(14, 32'h0001_0001, 2'd1); rd(14);

        tag = "R4";
        for (int q = 0; q < NQ; q++) begin
            wr(14, q);
            wr(8, 32'h0001_0000 + q * 32'h111 + 1);
        end
        for (int q = 0; q < NQ; q++) begin
            wr(14, q);
            rd(8);
            rd(12);
        end
        wr(12, 32'h55); rd(12);
        wr(16, 2);
        wr(16, 0);
        wr(16, 9);
        wr(16, 32'h0001_0003, 2'd1);

        tag = "R10";
        msg_en = 1'b1;
        wr(20, 1); rd(20);
        wr(14, 1); wr(22, 2); rd(22);
        wr(20, 5); rd(20);
        wr(14, 3); wr(22, 3); rd(22);
        wr(22, 0); rd(22);
        wr(20, 32'h0001_0002, 2'd1); rd(20);
        wr(20, 32'hFFFF); rd(20);

        tag = "R9";
        wr(20, 0);
        wr(14, 2); wr(22, 32'hFFFF);
        evt(1, 0);
        evt(0, 1);
        evt(0, 3);
        evt(0, 2);
        idle();

        tag = "R8";
        rd(19);
        evt(0, 1);
        idle();

        tag = "R7";
        rd(19, 2'd0);
        rd(19);
        msg_en = 1'b0;
        evt(1, 0);
        rd(19);
        evt(0, 0);
        step(1, 0, 2'd2, 19, 32'h0, 1, 0, 0);
        rd(19);
        idle();

        tag = "R8";
        evt(0, 2);
        msg_en = 1'b1;
        idle();
        msg_en = 1'b0;
        idle();
        rd(19);

        tag = "R11";
        msg_en = 1'b1;
        rd(24); rd(35); rd(36);
        wr(26, 32'hAB);
        rd(22);
        msg_en = 1'b0;
        rd(20); rd(22); rd(31); rd(32);
        wr(21, 32'h7);

        tag = "R12";
        rd(1); rd(13); rd(16); rd(17); rd(63);
        wr(1, 32'h77); wr(63, 32'h77);
        evt(0, 0);
        wr(19, 32'h0); rd(19);
        wr(12, 32'h9); rd(12);
        rd(4); rd(18);

        tag = "R6";
        wr(18, 32'h0F); rd(18);
        msg_en = 1'b1;
        wr(20, 2); wr(14, 1); wr(22, 1);
        evt(1, 0);
        wr(8, 32'h0, 2'd0);
        rd(4); rd(14); rd(18); rd(19); rd(20); rd(22);
        for (int q = 0; q < NQ; q++) begin
            wr(14, q);
            rd(8);
        end
        wr(18, 32'h3C); wr(20, 1); wr(4, 32'h9);
        wr(18, 32'h0000_0100);
        rd(18); rd(20); rd(4);
        wr(18, 32'h12); rd(18);
        wr(18, 32'h0000_1200, 2'd0);
        rd(18);
        idle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule